// File: doc/BRIEF.md
# Clearable Static RAM Array

A synchronous model of a 1024-word by 4-bit memory with separate input and output data paths. All control inputs are active low: chip select, write enable, output enable and a bulk-clear input. A 10-bit address selects one 4-bit word. The storage is organised as 64 rows of 64 bits. The upper six address bits pick the row and the lower four pick the 4-bit lane inside it.

The bulk clear makes the whole array read as zero without stepping through the addresses. Each row carries a valid flag, and all the flags are dropped in a single edge. A row whose flag is down reads as zero. The first write to such a row stores the new word, zero-fills the other lanes of that row and raises the flag. The clear acts only on a selected device, so a shared clear line can wipe selected memories while deselected ones keep their contents. For two cycles after a clear starts, a busy flag is high. During that window reads return zero and writes are discarded.

The tri-state output is modelled as a data bus together with an enable flag. The data bus is zero whenever the enable flag is low.

Top module: `zeroable_sram`

## Requirements
- R1: On a rising edge with csN=0, weN=0, clrN=1 and busy low, dataIn is stored at addr. A later read of that address returns it.
- R2: While csN=0, oeN=0, weN=1 and clrN=1, dataOutEn is 1 and dataOut shows the addressed word in the same cycle.
- R3: dataOutEn is 0 whenever csN=1, oeN=1, weN=0 or clrN=0. dataOut is 4'h0 whenever dataOutEn is 0. After the system reset arstN, busy and dataOutEn are 0.
- R4: With csN=1, a low clrN has no effect: stored contents are kept and busy stays low.
- R5: After a rising edge with csN=0 and clrN=0, every address reads 4'h0. A write into a cleared row leaves the other 15 lanes of that row reading 4'h0.
- R6: When a clear and a write fall on the same edge (csN=0, weN=0, clrN=0), the clear wins and the word is not stored.
- R7: busy is 1 for exactly the two cycles after a clear edge; a further clear restarts the window. While busy is 1, reads return 4'h0 and writes are discarded.
- R8: Address bits [9:4] select the row and bits [3:0] select the lane. Writes to different lanes of one row do not disturb each other.
- R9: An edge with csN=1 or weN=1 stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arstN | input | 1 | Asynchronous system reset, active low |
| csN | input | 1 | Chip select, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| clrN | input | 1 | Bulk clear, active low, needs csN low |
| addr | input | 10 | Word address |
| dataIn | input | 4 | Write data |
| dataOut | output | 4 | Read data, zero when not driven |
| dataOutEn | output | 1 | Output drive flag (low = high impedance) |
| busy | output | 1 | High for the two cycles after a clear starts |

## Verification
A bulk clear and a write can fall on the same edge, since both need only chip select low. The bench provokes this by asserting clrN and weN together, then reading the target address once the busy window ends. It expects zero because the clear wins. A second collision is a write issued inside the busy window. It is judged by reading that address afterwards, again expecting zero. Throughout, a behavioural array in the bench predicts dataOut, dataOutEn and busy on every cycle.

// File: rtl/zsram_pkg.sv
`timescale 1ns/1ps
package zsram_pkg;
  // Strobes sent from the control decoder to the array datapath
  typedef struct packed {
    logic wrEn;   // store dataIn on this edge
    logic clrEn;  // drop every row valid flag on this edge
    logic outEn;  // output bus driven this cycle
    logic blank;  // clear window active: force reads to zero
  } strobe_t;
endpackage

// File: rtl/zsram_ctrl.sv
`timescale 1ns/1ps
module zsram_ctrl #(
  parameter int BUSY_CYCLES = 2
) (
  input  logic               clk,
  input  logic               arstN,
  input  logic               csN,
  input  logic               weN,
  input  logic               oeN,
  input  logic               clrN,
  output zsram_pkg::strobe_t strb,
  output logic               busy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] busyCnt;
  logic clrReq, wrReq, rdReq;

  // Pin decode; the clear outranks a write.
  always_comb begin
    clrReq = !csN && !clrN;
    wrReq  = !csN && !weN && clrN;
    rdReq  = !csN && !oeN && weN && clrN;
  end

  // Busy window counter; a new clear reloads it.
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)                busyCnt <= '0;
    else if (clrReq)           busyCnt <= CNT_W'(BUSY_CYCLES);
    else if (busyCnt != '0)    busyCnt <= busyCnt - 1'b1;
  end

  always_comb begin
    busy       = (busyCnt != '0);
    strb.clrEn = clrReq;
    strb.wrEn  = wrReq && !busy;
    strb.outEn = rdReq;
    strb.blank = busy;
  end
endmodule

// File: rtl/zsram_dp.sv
`timescale 1ns/1ps
module zsram_dp #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4,
  parameter int COL_W  = 4
) (
  input  logic               clk,
  input  logic               arstN,
  input  zsram_pkg::strobe_t strb,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  dataIn,
  output logic [DATA_W-1:0]  dataOut
);
  localparam int ROW_W    = ADDR_W - COL_W;
  localparam int ROWS     = 1 << ROW_W;
  localparam int COLS     = 1 << COL_W;
  localparam int ROW_BITS = DATA_W * COLS;

  logic [ROW_W-1:0]    rowSel;
  logic [COL_W-1:0]    colSel;
  logic [ROW_BITS-1:0] laneMask, laneData, rdWord;
  logic [ROW_BITS-1:0] rowWord [ROWS];
  logic [ROWS-1:0]     rowValid;

  always_comb begin
    rowSel   = addr[ADDR_W-1:COL_W];
    colSel   = addr[COL_W-1:0];
    laneMask = ROW_BITS'({DATA_W{1'b1}}) << (int'(colSel) * DATA_W);
    laneData = ROW_BITS'(dataIn) << (int'(colSel) * DATA_W);
  end

  // One storage row plus its valid flag per generate step
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic                hit;
    logic                valid;
    logic [ROW_BITS-1:0] store;

    assign hit = strb.wrEn && (rowSel == ROW_W'(r));

    always_ff @(posedge clk) begin
      if (hit) store <= valid ? ((store & ~laneMask) | laneData) : laneData;
    end

    always_ff @(posedge clk or negedge arstN) begin
      if (!arstN)          valid <= 1'b0;
      else if (strb.clrEn) valid <= 1'b0;
      else if (hit)        valid <= 1'b1;
    end

    assign rowWord[r]  = store;
    assign rowValid[r] = valid;
  end

  always_comb begin
    rdWord  = rowWord[rowSel];
    dataOut = '0;
    if (strb.outEn && !strb.blank && rowValid[rowSel])
      dataOut = rdWord[int'(colSel) * DATA_W +: DATA_W];
  end
endmodule

// File: rtl/zeroable_sram.sv
`timescale 1ns/1ps
module zeroable_sram #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 4,
  parameter int COL_W       = 4,
  parameter int BUSY_CYCLES = 2
) (
  input  logic              clk,
  input  logic              arstN,
  input  logic              csN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              clrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              busy
);
  zsram_pkg::strobe_t strb;

  zsram_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .arstN(arstN), .csN(csN), .weN(weN), .oeN(oeN), .clrN(clrN),
    .strb(strb), .busy(busy)
  );

  zsram_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)) u_dp (
    .clk(clk), .arstN(arstN), .strb(strb), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut)
  );

  assign dataOutEn = strb.outEn;
endmodule

// File: rtl/zsram_chk.sv
`timescale 1ns/1ps
module zsram_chk #(
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              arstN,
  input logic              csN,
  input logic              weN,
  input logic              oeN,
  input logic              clrN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOutEn,
  input logic              busy
);
  // R3
  float_zero_chk: assert property (@(posedge clk) disable iff (!arstN)
    !dataOutEn |-> dataOut == '0);

  // R3
  out_gate_chk: assert property (@(posedge clk) disable iff (!arstN)
    (csN || oeN || !weN || !clrN) |-> !dataOutEn);

  // R7
  busy_first_chk: assert property (@(posedge clk) disable iff (!arstN)
    (!csN && !clrN) |=> busy);

  // R7
  busy_second_chk: assert property (@(posedge clk) disable iff (!arstN)
    (!csN && !clrN) |-> ##2 busy);

  // R4
  busy_cause_chk: assert property (@(posedge clk) disable iff (!arstN)
    (!busy && (csN || clrN)) |=> !busy);

  // R7
  blank_read_chk: assert property (@(posedge clk) disable iff (!arstN)
    busy |-> dataOut == '0);

  // R5
  cleared_read_chk: assert property (@(posedge clk) disable iff (!arstN)
    (!csN && !clrN) |=> dataOut == '0);
endmodule

bind zeroable_sram zsram_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_zeroable_sram.sv
`timescale 1ns/1ps
module sim_zeroable_sram;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       arstN = 1'b0;
  logic       csN = 1'b1, weN = 1'b1, oeN = 1'b1, clrN = 1'b1;
  logic [9:0] addr = '0;
  logic [3:0] dataIn = '0;
  logic [3:0] dataOut;
  logic       dataOutEn, busy;

  zeroable_sram u0 (
    .clk(clk), .arstN(arstN), .csN(csN), .weN(weN), .oeN(oeN), .clrN(clrN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn),
    .busy(busy)
  );

  int         compared = 0;
  int         mismatched = 0;
  int         busyLeft = 0;
  bit         finished = 0;
  logic [3:0] refMem [1024];

  task automatic step(input logic cs, input logic we, input logic oe,
                      input logic clr, input logic [9:0] a,
                      input logic [3:0] d, input string tag);
    logic       expEn, expB, wrOk;
    logic [3:0] expD;
    csN = cs; weN = we; oeN = oe; clrN = clr; addr = a; dataIn = d;
    #2;
    expB  = (busyLeft > 0);
    expEn = !cs && !oe && we && clr;
    expD  = (expEn && !expB) ? refMem[a] : 4'h0;
    compared++;
    if (dataOutEn !== expEn || dataOut !== expD || busy !== expB) begin
      mismatched++;
      $display("FAIL %s addr=%0d en/data/busy got %b/%h/%b expected %b/%h/%b",
               tag, a, dataOutEn, dataOut, busy, expEn, expD, expB);
    end
    @(posedge clk);
    wrOk = !cs && !we && clr && (busyLeft == 0);
    if (!cs && !clr) begin
      foreach (refMem[i]) refMem[i] = 4'h0;
      busyLeft = 2;
    end else begin
      if (busyLeft > 0) busyLeft--;
      if (wrOk) refMem[a] = d;
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [3:0] d, input string tag);
    step(1'b0, 1'b0, 1'b1, 1'b1, a, d, tag);
  endtask

  task automatic rd(input logic [9:0] a, input string tag);
    step(1'b0, 1'b1, 1'b0, 1'b1, a, 4'h0, tag);
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) wr(10'($urandom), 4'($urandom), "R1");
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [9:0] a;
    foreach (refMem[i]) refMem[i] = 4'h0;
    repeat (3) @(negedge clk);
    // R3: state after system reset
    compared++;
    if (busy !== 1'b0 || dataOutEn !== 1'b0 || dataOut !== 4'h0) begin
      mismatched++;
      $display("FAIL R3 reset en/data/busy got %b/%h/%b expected 0/0/0",
               dataOutEn, dataOut, busy);
    end
    arstN = 1'b1;
    @(negedge clk);

    // R8: all lanes of one row, then read back
    for (int c = 0; c < 16; c++) wr({6'd5, 4'(c)}, 4'(c ^ 9), "R8");
    for (int c = 0; c < 16; c++) rd({6'd5, 4'(c)}, "R8");

    // R1 / R2: random writes and reads
    fill(200);
    for (int i = 0; i < 200; i++) rd(10'($urandom), "R2");

    // R3: every combination of the four control pins
    for (int k = 0; k < 16; k++)
      step(k[0], k[1], k[2], k[3], 10'($urandom), 4'($urandom), "R3");
    fill(100);

    // R9: writes with chip select high or write enable high
    a = 10'd77;
    wr(a, 4'h6, "R9");
    step(1'b1, 1'b0, 1'b1, 1'b1, a, 4'h9, "R9");
    step(1'b0, 1'b1, 1'b1, 1'b1, a, 4'hC, "R9");
    rd(a, "R9");

    // R4: clear while deselected keeps contents
    step(1'b1, 1'b1, 1'b1, 1'b0, 10'd0, 4'h0, "R4");
    step(1'b1, 1'b0, 1'b0, 1'b0, 10'd1, 4'h3, "R4");
    for (int i = 0; i < 40; i++) rd(10'($urandom), "R4");
    rd(a, "R4");

    // R6: clear and write on one edge
    fill(50);
    step(1'b0, 1'b0, 1'b1, 1'b0, 10'd300, 4'hF, "R6");
    step(1'b1, 1'b1, 1'b1, 1'b1, 10'd300, 4'h0, "R6");
    step(1'b1, 1'b1, 1'b1, 1'b1, 10'd300, 4'h0, "R6");
    rd(10'd300, "R6");

    // R7: busy window, blanked read, dropped write, restart
    fill(50);
    wr(10'd512, 4'hA, "R7");
    step(1'b0, 1'b1, 1'b0, 1'b0, 10'd512, 4'h0, "R7");
    rd(10'd512, "R7");
    wr(10'd513, 4'h5, "R7");
    rd(10'd513, "R7");
    rd(10'd512, "R7");
    wr(10'd514, 4'h7, "R7");
    step(1'b0, 1'b1, 1'b1, 1'b0, 10'd0, 4'h0, "R7");
    step(1'b0, 1'b1, 1'b1, 1'b0, 10'd0, 4'h0, "R7");
    rd(10'd514, "R7");
    rd(10'd514, "R7");
    rd(10'd514, "R7");

    // R5: every location zero, then zero-fill of a touched row
    for (int i = 0; i < 1024; i++) rd(10'(i), "R5");
    wr({6'd9, 4'd3}, 4'hE, "R5");
    for (int c = 0; c < 16; c++) rd({6'd9, 4'(c)}, "R5");

    // R1 / R2: random mixed traffic with rare clears
    for (int i = 0; i < 3000; i++) begin
      logic cs, we, oe, clr;
      cs  = ($urandom_range(0, 9) == 0);
      we  = ($urandom_range(0, 2) != 0);
      oe  = ($urandom_range(0, 5) == 0);
      clr = ($urandom_range(0, 63) != 0);
      step(cs, we, oe, clr, 10'($urandom_range(0, 63)), 4'($urandom), "R2");
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule